// File: doc/BRIEF.md
# Execute-in-Place SPI Flash Read Bridge

This block lets a processor fetch code or constants straight out of a serial flash device as if it were ordinary read-only memory. A read burst arrives on an AXI4-style address channel. The block turns it into one flash read frame: chip select goes low, a read opcode and a 24-bit byte address are shifted out, and the returned bytes are clocked in. The bytes are packed into 32-bit words, held in a 64-entry word buffer, and handed back as read beats with a last-beat flag.

Only one flash device is ever selected, and only read frames are ever produced. The serial clock always runs at half the block clock. A two-bit lane input selects how many data lines carry the returned bytes: one, two or four. Incrementing bursts stream through the buffer, and the serial clock pauses when the buffer is full. Wrapping bursts fetch their whole aligned block, then replay it starting at the requested beat. Fixed and reserved burst types are refused with an error response on every beat, and no serial traffic is produced for them.

Top module: `xip_flash_reader`

## Requirements
- R1: At most one burst is in flight. `ar_ready` is low from the cycle after an address handshake until the handshake of that burst's last beat.
- R2: A burst whose type is FIXED (0) or reserved (3), or a WRAP (2) burst whose `ar_len` is not 1, 3, 7 or 15, returns `ar_len`+1 beats. Each of these beats has `r_resp` = 2'b10 and `r_data` = 0, and the final beat has `r_last` set. Chip select never falls for such a burst.
- R3: For an accepted burst, `spi_io_o[0]` carries 32 bits MSB-first while chip select is low, one bit per rising edge of `spi_sck`. The first 8 bits are the opcode and the next 24 bits are the fetch address. The opcode is 0x03 for lane mode 0 or 3, 0x3B for lane mode 1, and 0x6B for lane mode 2.
- R4: `spi_sck` is low whenever chip select is high. While chip select is low, `spi_sck` is never high for two consecutive block clock cycles.
- R5: An INCR (1) burst fetches from the address with bits 1:0 cleared. It returns `ar_len`+1 consecutive words in ascending address order.
- R6: A WRAP burst fetches from the address aligned down to (`ar_len`+1)×4 bytes. Its first beat is the word at index (`ar_addr`[9:2] AND `ar_len`). Each later beat takes the next index, modulo `ar_len`+1.
- R7: Within each byte, bits arrive MSB-first. In lane mode 0 or 3 one bit per rising edge is taken from `spi_io_i[1]`. In mode 1 two bits are taken from `spi_io_i[1:0]`, with bit 1 the more significant. In mode 2 four bits are taken from `spi_io_i[3:0]`. The first byte received lands in bits 7:0 of each word and the fourth in bits 31:24.
- R8: The buffer holds 64 words. When the reader stalls, the serial clock stops with chip select still low, and no word is lost or overwritten.
- R9: While `r_valid` is high and `r_ready` is low, `r_valid`, `r_data`, `r_resp` and `r_last` hold their values.
- R10: `r_last` is high on beat number `ar_len` (counting from 0) and on no other beat.
- R11: After reset, `ar_ready` is 1, `r_valid` is 0, `spi_cs_n` is 1, `spi_sck` is 0 and `spi_io_oe` is 0.
- R12: `spi_io_oe` is 4'b0001 while the opcode and address are shifted out, and 4'b0000 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial clock runs at half this rate |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_mode | input | 2 | Data lane count: 0/3 single, 1 dual, 2 quad; latched at frame start |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_addr | input | 24 | Byte address of the burst |
| ar_len | input | 8 | Beats in the burst minus one |
| ar_burst | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat accepted |
| r_data | output | 32 | Read beat data |
| r_resp | output | 2 | Read response: 2'b00 okay, 2'b10 slave error |
| r_last | output | 1 | Final beat of the burst |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_io_o | output | 4 | Serial data out; only bit 0 is used |
| spi_io_oe | output | 4 | Per-line output enable |
| spi_io_i | input | 4 | Serial data in |

## Verification
The bench goes after wrapping bursts that start at their last index. A design that did not align the fetch address, or did not wrap the beat index, would return words from the next block. Fixed, reserved and badly sized wrapping bursts are checked for silence on the serial lines, because a design that decoded the burst type too late would still drop chip select. A 256-beat burst is held off long enough to fill the buffer. A design without flow control would then overwrite unread words, and one that paused the serial clock in the wrong state would leave the clock high or release chip select. Each lane count is also tested with a single-word read, where swapped lanes or a byte order that is not little-endian show up right away.

// File: rtl/xipr_pkg.sv
package xipr_pkg;

  localparam int XIPR_ADDR_W = 24;
  localparam int XIPR_LEN_W  = 8;
  localparam int XIPR_WORD_W = 32;

  localparam logic [1:0] BURST_FIXED = 2'd0;
  localparam logic [1:0] BURST_INCR  = 2'd1;
  localparam logic [1:0] BURST_WRAP  = 2'd2;
  localparam logic [1:0] BURST_RSVD  = 2'd3;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } xipr_lane_e;

  // mode 3 is folded onto the single-lane case
  function automatic xipr_lane_e lane_of(input logic [1:0] m);
    case (m)
      2'd1:    return LANE_X2;
      2'd2:    return LANE_X4;
      default: return LANE_X1;
    endcase
  endfunction

  function automatic logic [7:0] read_opcode(input logic [1:0] m);
    case (lane_of(m))
      LANE_X2: return 8'h3B;
      LANE_X4: return 8'h6B;
      default: return 8'h03;
    endcase
  endfunction

  // captures per byte, minus one
  function automatic logic [2:0] caps_per_byte_m1(input logic [1:0] m);
    case (lane_of(m))
      LANE_X2: return 3'd3;
      LANE_X4: return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [7:0] shift_lanes(input logic [7:0] b, input logic [3:0] io,
                                             input logic [1:0] m);
    case (lane_of(m))
      LANE_X2: return {b[5:0], io[1:0]};
      LANE_X4: return {b[3:0], io[3:0]};
      default: return {b[6:0], io[1]};
    endcase
  endfunction

  function automatic logic wrap_len_ok(input logic [XIPR_LEN_W-1:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

  function automatic logic burst_rejected(input logic [1:0] burst,
                                          input logic [XIPR_LEN_W-1:0] len);
    return (burst == BURST_FIXED) || (burst == BURST_RSVD) ||
           ((burst == BURST_WRAP) && !wrap_len_ok(len));
  endfunction

  function automatic logic [XIPR_ADDR_W-1:0] fetch_base(input logic [XIPR_ADDR_W-1:0] a,
                                                        input logic [1:0] burst,
                                                        input logic [XIPR_LEN_W-1:0] len);
    logic [XIPR_ADDR_W-1:0] span_mask;
    span_mask = XIPR_ADDR_W'({len, 2'b11});
    if (burst == BURST_WRAP) return a & ~span_mask;
    return {a[XIPR_ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic [XIPR_LEN_W-1:0] wrap_start(input logic [XIPR_ADDR_W-1:0] a,
                                                      input logic [XIPR_LEN_W-1:0] len);
    return a[XIPR_LEN_W+1:2] & len;
  endfunction

endpackage

// File: rtl/xipr_word_buf.sv
module xipr_word_buf #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/xipr_spi_engine.sv
module xipr_spi_engine
  import xipr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [XIPR_ADDR_W-1:0] start_addr,
  input  logic [XIPR_LEN_W:0]    words,
  input  logic [1:0]             lane_mode,
  input  logic                   room,
  output logic                   busy,
  output logic                   word_valid,
  output logic [XIPR_WORD_W-1:0] word_data,
  output logic                   spi_sck,
  output logic                   spi_cs_n,
  output logic [3:0]             spi_io_o,
  output logic [3:0]             spi_io_oe,
  input  logic [3:0]             spi_io_i
);

  typedef enum logic [1:0] {E_IDLE, E_CMD, E_DATA} eng_st_e;

  eng_st_e                st_q;
  logic                   sck_q, cs_n_q, fin_q;
  logic [31:0]            sh_q;
  logic [5:0]             bitcnt_q;
  logic [1:0]             mode_q;
  logic [7:0]             byte_q;
  logic [2:0]             cap_cnt_q;
  logic [1:0]             byte_idx_q;
  logic [31:0]            acc_q;
  logic [XIPR_LEN_W:0]    left_q;

  // named events for the checks below
  logic       cap_ev, byte_ev, word_ev;
  logic [7:0] byte_nxt;

  assign cap_ev   = (st_q == E_DATA) && !sck_q && room;
  assign byte_nxt = shift_lanes(byte_q, spi_io_i, mode_q);
  assign byte_ev  = cap_ev && (cap_cnt_q == caps_per_byte_m1(mode_q));
  assign word_ev  = byte_ev && (byte_idx_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= E_IDLE;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      fin_q      <= 1'b0;
      sh_q       <= '0;
      bitcnt_q   <= '0;
      mode_q     <= '0;
      byte_q     <= '0;
      cap_cnt_q  <= '0;
      byte_idx_q <= '0;
      acc_q      <= '0;
      left_q     <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      case (st_q)
        E_IDLE: begin
          if (start) begin
            cs_n_q     <= 1'b0;
            sck_q      <= 1'b0;
            sh_q       <= {read_opcode(lane_mode), start_addr};
            bitcnt_q   <= 6'd32;
            mode_q     <= lane_mode;
            cap_cnt_q  <= '0;
            byte_idx_q <= '0;
            left_q     <= words;
            fin_q      <= 1'b0;
            st_q       <= E_CMD;
          end
        end
        E_CMD: begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q    <= 1'b0;
            sh_q     <= {sh_q[30:0], 1'b0};
            bitcnt_q <= bitcnt_q - 6'd1;
            if (bitcnt_q == 6'd1) st_q <= E_DATA;
          end
        end
        E_DATA: begin
          if (!sck_q) begin
            if (cap_ev) begin
              sck_q     <= 1'b1;
              byte_q    <= byte_nxt;
              cap_cnt_q <= byte_ev ? 3'd0 : cap_cnt_q + 3'd1;
              if (byte_ev) begin
                byte_idx_q <= byte_idx_q + 2'd1;
                if (word_ev) begin
                  word_valid <= 1'b1;
                  word_data  <= {byte_nxt, acc_q[23:0]};
                  left_q     <= left_q - 1'b1;
                  if (left_q == 9'd1) fin_q <= 1'b1;
                end else begin
                  acc_q[{byte_idx_q, 3'b000} +: 8] <= byte_nxt;
                end
              end
            end
          end else begin
            sck_q <= 1'b0;
            if (fin_q) begin
              cs_n_q <= 1'b1;
              fin_q  <= 1'b0;
              st_q   <= E_IDLE;
            end
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != E_IDLE);
  assign spi_sck   = sck_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_io_o  = {3'b000, sh_q[31]};
  assign spi_io_oe = (st_q == E_CMD) ? 4'b0001 : 4'b0000;

  assert_sck_half_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sck) |=> !spi_sck);

  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_oe_selected_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe != 4'b0000) |-> (!spi_cs_n && $onehot0(spi_io_oe)));

  assert_mosi_stable_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_io_o));

  assert_capture_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |-> (!spi_cs_n && (spi_io_oe == 4'b0000)));

endmodule

// File: rtl/xipr_burst_ctrl.sv
module xipr_burst_ctrl
  import xipr_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  localparam int PTR_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = XIPR_LEN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ar_valid,
  output logic                   ar_ready,
  input  logic [XIPR_ADDR_W-1:0] ar_addr,
  input  logic [XIPR_LEN_W-1:0]  ar_len,
  input  logic [1:0]             ar_burst,
  output logic                   r_valid,
  input  logic                   r_ready,
  output logic [XIPR_WORD_W-1:0] r_data,
  output logic [1:0]             r_resp,
  output logic                   r_last,
  output logic                   eng_start,
  output logic [XIPR_ADDR_W-1:0] eng_addr,
  output logic [CNT_W-1:0]       eng_words,
  input  logic                   eng_busy,
  input  logic                   word_valid,
  output logic [PTR_W-1:0]       buf_wr_addr,
  output logic [PTR_W-1:0]       buf_rd_addr,
  input  logic [XIPR_WORD_W-1:0] buf_rd_data,
  output logic                   room
);

  typedef enum logic [1:0] {C_IDLE, C_RUN, C_ERR} ctrl_st_e;

  ctrl_st_e               st_q;
  logic [XIPR_LEN_W-1:0]  len_q, off_q;
  logic                   wrap_q, start_q;
  logic [XIPR_ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]       wcnt_q, rcnt_q;

  logic             ar_fire, r_fire, beat_last, avail;
  logic [CNT_W-1:0] fill, total;

  assign ar_fire   = ar_valid && ar_ready;
  assign r_fire    = r_valid && r_ready;
  assign beat_last = (rcnt_q[XIPR_LEN_W-1:0] == len_q);
  assign total     = {1'b0, len_q} + 9'd1;
  assign fill      = wcnt_q - rcnt_q;
  assign room      = fill < CNT_W'(BUF_DEPTH);
  assign avail     = wrap_q ? (wcnt_q == total) : (wcnt_q > rcnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= C_IDLE;
      len_q   <= '0;
      off_q   <= '0;
      wrap_q  <= 1'b0;
      start_q <= 1'b0;
      addr_q  <= '0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (word_valid) wcnt_q <= wcnt_q + 9'd1;
      case (st_q)
        C_IDLE: begin
          if (ar_fire) begin
            len_q  <= ar_len;
            wrap_q <= (ar_burst == BURST_WRAP);
            off_q  <= wrap_start(ar_addr, ar_len);
            addr_q <= fetch_base(ar_addr, ar_burst, ar_len);
            wcnt_q <= '0;
            rcnt_q <= '0;
            if (burst_rejected(ar_burst, ar_len)) begin
              st_q <= C_ERR;
            end else begin
              st_q    <= C_RUN;
              start_q <= 1'b1;
            end
          end
        end
        default: begin
          if (r_fire) begin
            rcnt_q <= rcnt_q + 9'd1;
            if (beat_last) st_q <= C_IDLE;
          end
        end
      endcase
    end
  end

  assign ar_ready    = (st_q == C_IDLE) && !eng_busy && !start_q;
  assign r_valid     = (st_q == C_ERR) || ((st_q == C_RUN) && avail);
  assign r_data      = (st_q == C_RUN) ? buf_rd_data : '0;
  assign r_resp      = (st_q == C_ERR) ? RESP_SLVERR : RESP_OKAY;
  assign r_last      = (st_q != C_IDLE) && beat_last;
  assign eng_start   = start_q;
  assign eng_addr    = addr_q;
  assign eng_words   = total;
  assign buf_wr_addr = wcnt_q[PTR_W-1:0];
  assign buf_rd_addr = wrap_q ? PTR_W'((off_q + rcnt_q[XIPR_LEN_W-1:0]) & len_q)
                              : rcnt_q[PTR_W-1:0];

  assert_one_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> !ar_ready);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (fill < CNT_W'(BUF_DEPTH)));

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_resp) && $stable(r_last)));

  assert_last_ends_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fire && r_last) |=> !r_valid);

endmodule

// File: rtl/xip_flash_reader.sv
module xip_flash_reader
  import xipr_pkg::*;
#(
  parameter int BUF_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  lane_mode,
  input  logic        ar_valid,
  output logic        ar_ready,
  input  logic [23:0] ar_addr,
  input  logic [7:0]  ar_len,
  input  logic [1:0]  ar_burst,
  output logic        r_valid,
  input  logic        r_ready,
  output logic [31:0] r_data,
  output logic [1:0]  r_resp,
  output logic        r_last,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic [3:0]  spi_io_o,
  output logic [3:0]  spi_io_oe,
  input  logic [3:0]  spi_io_i
);

  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int CNT_W = XIPR_LEN_W + 1;

  logic                   eng_start, eng_busy, word_valid, room;
  logic [XIPR_ADDR_W-1:0] eng_addr;
  logic [CNT_W-1:0]       eng_words;
  logic [XIPR_WORD_W-1:0] word_data, buf_rd_data;
  logic [PTR_W-1:0]       buf_wr_addr, buf_rd_addr;

  xipr_burst_ctrl #(.BUF_DEPTH(BUF_DEPTH)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ar_valid   (ar_valid),
    .ar_ready   (ar_ready),
    .ar_addr    (ar_addr),
    .ar_len     (ar_len),
    .ar_burst   (ar_burst),
    .r_valid    (r_valid),
    .r_ready    (r_ready),
    .r_data     (r_data),
    .r_resp     (r_resp),
    .r_last     (r_last),
    .eng_start  (eng_start),
    .eng_addr   (eng_addr),
    .eng_words  (eng_words),
    .eng_busy   (eng_busy),
    .word_valid (word_valid),
    .buf_wr_addr(buf_wr_addr),
    .buf_rd_addr(buf_rd_addr),
    .buf_rd_data(buf_rd_data),
    .room       (room)
  );

  xipr_spi_engine eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eng_start),
    .start_addr (eng_addr),
    .words      (eng_words),
    .lane_mode  (lane_mode),
    .room       (room),
    .busy       (eng_busy),
    .word_valid (word_valid),
    .word_data  (word_data),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_io_o   (spi_io_o),
    .spi_io_oe  (spi_io_oe),
    .spi_io_i   (spi_io_i)
  );

  xipr_word_buf #(.DEPTH(BUF_DEPTH), .WIDTH(XIPR_WORD_W)) buf_i (
    .clk     (clk),
    .wr_en   (word_valid),
    .wr_addr (buf_wr_addr),
    .wr_data (word_data),
    .rd_addr (buf_rd_addr),
    .rd_data (buf_rd_data)
  );

  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && (r_resp == RESP_SLVERR)) |-> (spi_cs_n && (r_data == '0)));

  assert_busy_blocks_address_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !ar_ready);

endmodule

// File: tb/xip_flash_reader_tb_top.sv
module xip_flash_reader_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lane_mode = 2'd0;
  logic        ar_valid = 1'b0;
  logic        ar_ready;
  logic [23:0] ar_addr = '0;
  logic [7:0]  ar_len = '0;
  logic [1:0]  ar_burst = 2'd1;
  logic        r_valid;
  logic        r_ready = 1'b0;
  logic [31:0] r_data;
  logic [1:0]  r_resp;
  logic        r_last;
  logic        spi_sck, spi_cs_n;
  logic [3:0]  spi_io_o, spi_io_oe;
  logic [3:0]  spi_io_i = 4'd0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  xip_flash_reader dut_i (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_burst(ar_burst), .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
  );

  // ---------------- flash content and expectations ----------------
  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'hA5;
  endfunction

  function automatic logic [31:0] fword(input logic [23:0] a);
    return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
  endfunction

  function automatic logic [7:0] exp_opcode(input logic [1:0] m);
    if (m == 2'd1) return 8'h3B;
    if (m == 2'd2) return 8'h6B;
    return 8'h03;
  endfunction

  function automatic int lanes_for(input logic [1:0] m);
    if (m == 2'd1) return 2;
    if (m == 2'd2) return 4;
    return 1;
  endfunction

  function automatic bit is_refused(input logic [1:0] b, input logic [7:0] len);
    if (b == 2'd0 || b == 2'd3) return 1'b1;
    if (b == 2'd2) return !(len == 8'd1 || len == 8'd3 || len == 8'd7 || len == 8'd15);
    return 1'b0;
  endfunction

  function automatic logic [23:0] exp_base(input logic [23:0] a, input logic [1:0] b,
                                           input logic [7:0] len);
    int span;
    span = (int'(len) + 1) * 4;
    if (b == 2'd2) return a - 24'(int'(a) % span);
    return a - 24'(a[1:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash device model ----------------
  int          cur_nb = 1;
  int          m_rise = 0;
  int          m_dbit = 0;
  int          cs_falls = 0;
  int          rises_total = 0;
  int          oe_bad = 0;
  logic [31:0] m_cmd = '0;
  logic        m_cs_prev = 1'b1;
  logic        m_sck_prev = 1'b0;

  always @(spi_sck or spi_cs_n) begin
    if (spi_cs_n !== m_cs_prev) begin
      if (!spi_cs_n) begin
        m_rise = 0;
        m_dbit = 0;
        cs_falls++;
      end
      m_cs_prev = spi_cs_n;
    end
    if (spi_sck !== m_sck_prev) begin
      if (spi_sck && !spi_cs_n) begin
        rises_total++;
        if (m_rise < 32) begin
          m_cmd = {m_cmd[30:0], spi_io_o[0]};
          if (spi_io_oe !== 4'b0001) oe_bad++;
        end else if (spi_io_oe !== 4'b0000) begin
          oe_bad++;
        end
        m_rise++;
      end else if (!spi_sck && !spi_cs_n && m_rise >= 32) begin
        logic [7:0] b;
        logic [3:0] chunk;
        int pos;
        pos   = m_dbit % 8;
        b     = fbyte(m_cmd[23:0] + 24'(m_dbit / 8));
        chunk = 4'((b >> (8 - cur_nb - pos)) & ((1 << cur_nb) - 1));
        if (cur_nb == 4)      spi_io_i = chunk;
        else if (cur_nb == 2) spi_io_i = {2'b00, chunk[1:0]};
        else                  spi_io_i = {2'b00, chunk[0], 1'b0};
        m_dbit += cur_nb;
      end
      m_sck_prev = spi_sck;
    end
  end

  // serial clock shape monitor (R4)
  int   sck_bad = 0;
  logic sck_hi_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_sck) sck_bad++;
      if (sck_hi_prev && !spi_cs_n && spi_sck) sck_bad++;
      sck_hi_prev = spi_sck && !spi_cs_n;
    end
  end

  // ---------------- burst driver and checker ----------------
  task automatic run_burst(input logic [23:0] addr, input logic [7:0] len,
                           input logic [1:0] burst, input logic [1:0] mode,
                           input int rdy_pct, input int hold_cycles);
    int          falls0;
    bit          refused, hold_prev, done, rr;
    logic [23:0] base;
    logic [7:0]  off;
    logic [31:0] pd;
    logic [1:0]  pr;
    logic        pl;
    int          n;
    string       tag;
    logic [31:0] ed;
    falls0  = cs_falls;
    refused = is_refused(burst, len);
    base    = exp_base(addr, burst, len);
    off     = addr[9:2] & len;
    if (refused)            tag = "R2";
    else if (burst == 2'd2) tag = "R6";
    else if (len == 8'd0)   tag = "R7";
    else                    tag = "R5";

    @(negedge clk);
    lane_mode = mode;
    cur_nb    = lanes_for(mode);
    ar_valid  = 1'b1;
    ar_addr   = addr;
    ar_len    = len;
    ar_burst  = burst;
    r_ready   = 1'b0;
    done      = 1'b0;
    while (!done) begin
      done = ar_ready;
      @(posedge clk);
    end
    @(negedge clk);
    ar_valid = 1'b0;
    chk(ar_ready == 1'b0, "R1", "ar_ready after accept", 64'(ar_ready), 64'd0);

    if (hold_cycles > 0) begin
      int r0;
      repeat (hold_cycles) @(negedge clk);
      r0 = rises_total;
      repeat (20) @(negedge clk);
      chk(rises_total == r0 && !spi_cs_n && !spi_sck, "R8", "serial clock paused",
          64'(rises_total - r0), 64'd0);
    end

    n         = 0;
    hold_prev = 1'b0;
    pd = '0; pr = '0; pl = 1'b0;
    while (n <= int'(len)) begin
      if (hold_prev)
        chk(r_valid && r_data == pd && r_resp == pr && r_last == pl, "R9",
            "beat held under stall", {31'd0, r_valid, r_data}, {32'd1, pd});
      if (n > 0 && !r_valid && !refused) chk(ar_ready == 1'b0, "R1", "ar_ready mid-burst",
                                              64'(ar_ready), 64'd0);
      rr      = ($urandom % 100) < rdy_pct;
      r_ready = rr;
      if (r_valid && rr) begin
        if (refused) ed = 32'd0;
        else if (burst == 2'd2) ed = fword(base + 24'(4 * ((int'(off) + n) & int'(len))));
        else ed = fword(base + 24'(4 * n));
        chk(r_data == ed, tag, $sformatf("data beat %0d", n), 64'(r_data), 64'(ed));
        chk(r_resp == (refused ? 2'b10 : 2'b00), tag, "response", 64'(r_resp),
            64'(refused ? 2'b10 : 2'b00));
        chk(r_last == (n == int'(len)), "R10", $sformatf("last flag beat %0d", n),
            64'(r_last), 64'(n == int'(len)));
        n++;
      end
      hold_prev = r_valid && !rr;
      pd = r_data; pr = r_resp; pl = r_last;
      @(negedge clk);
    end
    r_ready = 1'b0;
    while (!ar_ready) @(negedge clk);
    if (refused) begin
      chk(cs_falls == falls0, "R2", "chip select stayed high", 64'(cs_falls - falls0), 64'd0);
    end else begin
      chk(m_cmd == {exp_opcode(mode), base}, "R3", "opcode and address", 64'(m_cmd),
          64'({exp_opcode(mode), base}));
      chk(oe_bad == 0, "R12", "output enables", 64'(oe_bad), 64'd0);
      chk(sck_bad == 0, "R4", "serial clock shape", 64'(sck_bad), 64'd0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ar_ready == 1'b1, "R11", "ar_ready after reset", 64'(ar_ready), 64'd1);
    chk(r_valid == 1'b0, "R11", "r_valid after reset", 64'(r_valid), 64'd0);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R11", "select and clock after reset",
        {62'd0, spi_cs_n, spi_sck}, 64'd2);
    chk(spi_io_oe == 4'd0, "R11", "enables after reset", 64'(spi_io_oe), 64'd0);

    // directed: single words per lane mode for byte packing (R7)
    run_burst(24'h000100, 8'd0, 2'd1, 2'd0, 100, 0);
    run_burst(24'h012345, 8'd0, 2'd1, 2'd1, 100, 0);
    run_burst(24'hABCDE8, 8'd0, 2'd1, 2'd2, 100, 0);
    run_burst(24'h00F00F, 8'd0, 2'd1, 2'd3, 100, 0);
    // directed: incrementing and wrapping corners (R5, R6)
    run_burst(24'h100007, 8'd5, 2'd1, 2'd2, 70, 0);
    run_burst(24'h200018, 8'd3, 2'd2, 2'd1, 60, 0);
    run_burst(24'hFFFFFC, 8'd15, 2'd2, 2'd2, 50, 0);
    run_burst(24'h000040, 8'd1, 2'd2, 2'd0, 100, 0);
    // directed: refused bursts (R2)
    run_burst(24'h001000, 8'd3, 2'd0, 2'd2, 80, 0);
    run_burst(24'h002000, 8'd0, 2'd3, 2'd0, 100, 0);
    run_burst(24'h003000, 8'd5, 2'd2, 2'd1, 50, 0);
    // directed: long burst with the reader stalled until the buffer fills (R8)
    run_burst(24'h340000, 8'd255, 2'd1, 2'd2, 90, 1500);

    // constrained random mix
    for (int i = 0; i < 30; i++) begin
      logic [1:0] b;
      logic [7:0] l;
      int         sel;
      sel = $urandom % 10;
      if (sel < 5) begin
        b = 2'd1;
        l = 8'($urandom % 24);
      end else if (sel < 9) begin
        b = 2'd2;
        l = 8'((2 << ($urandom % 4)) - 1);
      end else begin
        b = 2'($urandom % 4);
        l = 8'($urandom % 8);
      end
      run_burst(24'($urandom), l, b, 2'($urandom % 4), 30 + ($urandom % 71), 0);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule